// File: doc/BRIEF.md
# DMA Channel Sequencer with Bus-Exception Abort

This block runs one DMA channel. Once started, it moves a programmed number of words. For each word it reads from an incrementing source pointer into a holding register, then writes that word to an incrementing destination pointer. Both phases use a plain request/acknowledge bus-master port.

While it runs, the block drives three things:
- a strobe that tells a peripheral which side of the transfer concerns it;
- an optional tag bit that marks its own bus cycles to outside observers;
- an output enable standing in for pad tri-state control.

Two abnormal events are handled:
- **Reset.** An asynchronous reset kills the channel at once.
- **Bus error.** A bus error reported on a transaction ends that transaction and leaves the channel locked until reset. The half-moved word is thrown away.

Completion and error are recorded in an event register. Each event can raise an interrupt through a mask.

Software reaches the block through a write-only configuration port with a 3-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit0 start, bit1 strobe side, bit2 tag enable |
| 1 | Count | word count |
| 2 | Source pointer | start address for reads |
| 3 | Destination pointer | start address for writes |
| 4 | Interrupt mask | bit0 done, bit1 error |
| 5 | Event clear | write 1 to clear: bit0 done, bit1 error |

Top module: `dma_abort_ctrl`

## Requirements
- R1: Asserting `rst_n` low immediately forces the channel idle: `busy`, `dead`, `evt_done`, `evt_err` and `irq` read 0 without waiting for a clock edge.
- R2: If reset is asserted while a transaction is open, `bus_req` and `bus_oe` drop in the same instant. `bus_oe` is high exactly while `busy` is high.
- R3: When `bus_err` is high while `bus_req` is high, the transaction ends at that clock edge. After that edge `evt_err` and `dead` are 1 and `bus_req` is 0.
- R4: `irq` is high exactly while an event bit is set whose mask bit is set. With mask bit1 clear, a bus error leaves `irq` low.
- R5: Once `dead` is set, the channel stays dead and ignores start writes until reset. The holding register is cleared by the error, so `bus_wdata` reads 0.
- R6: `pdack` is low in any cycle in which `bus_err` is high.
- R7: With control bit1 = 0, `pdack` is high during source reads. With bit1 = 1, it is high during destination writes. It is never high in the other phase.
- R8: With control bit2 = 1, `tc_out` is high in every cycle of every transaction. With bit2 = 0, it stays low.
- R9: Writing control bit0 = 1 while idle with a nonzero count starts the channel. Word i is read from source+i and written to destination+i with the data read. After the last write, the channel returns idle and sets `evt_done`.
- R10: Writing 1 to a bit of address 5 clears that event bit. Writing 0 leaves it unchanged.
- R11: When `bus_ack` and `bus_err` are high together, the error wins: no data is taken and the channel goes dead.
- R12: Each phase holds its request, address and data unchanged until `bus_ack` or `bus_err` arrives, however many wait cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = destination write, 0 = source read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Holding register contents (write data) |
| bus_oe | output | 1 | Enable for address, data and control pads |
| bus_rdata | input | DW | Read data from the bus |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_err | input | 1 | Transaction bus error |
| pdack | output | 1 | Peripheral acknowledge strobe |
| tc_out | output | 1 | Transaction tag bit |
| busy | output | 1 | Channel is transferring |
| dead | output | 1 | Channel is locked by a bus error |
| evt_done | output | 1 | Done event |
| evt_err | output | 1 | Error event |
| irq | output | 1 | Interrupt request |

## Verification
The hard case is a bus error that lands on one particular transaction of a multi-word transfer. The most awkward version hits the write phase with a freshly loaded holding register while the acknowledge is also high.

The bench reaches every such point by sweeping the index of the failing transaction over all read and write phases of transfers of one to three words. It combines this with zero or one wait cycle and both strobe sides. On the wait-cycle runs the error is raised together with the acknowledge. After each error the bench checks that the channel stays dead through a fresh start and that the holding register reads 0.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_DEAD = 2'd3
  } dmac_state_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_CNT  = 3'd1;
  localparam logic [2:0] REG_SRC  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_MASK = 3'd4;
  localparam logic [2:0] REG_EVCLR = 3'd5;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          idle,
  input  logic          done_set,
  input  logic          err_set,
  output logic          start,
  output logic [CW-1:0] cnt_cfg,
  output logic [AW-1:0] src_cfg,
  output logic [AW-1:0] dst_cfg,
  output logic          sd_mode,
  output logic          tc_en,
  output logic [1:0]    events,
  output logic          irq
);
  import dmac_pkg::*;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic          sd_q, sd_d, tc_q, tc_d;
  logic [1:0]    mask_q, mask_d, ev_q, ev_d;
  logic          wr_idle;

  assign wr_idle = cfg_we && idle;

  always_comb begin
    cnt_d  = cnt_q;
    src_d  = src_q;
    dst_d  = dst_q;
    sd_d   = sd_q;
    tc_d   = tc_q;
    mask_d = mask_q;
    ev_d   = ev_q;
    if (wr_idle && cfg_addr == REG_CNT) cnt_d = cfg_wdata[CW-1:0];
    if (wr_idle && cfg_addr == REG_SRC) src_d = cfg_wdata[AW-1:0];
    if (wr_idle && cfg_addr == REG_DST) dst_d = cfg_wdata[AW-1:0];
    if (wr_idle && cfg_addr == REG_CTRL) begin
      sd_d = cfg_wdata[1];
      tc_d = cfg_wdata[2];
    end
    if (cfg_we && cfg_addr == REG_MASK) mask_d = cfg_wdata[1:0];
    if (cfg_we && cfg_addr == REG_EVCLR) ev_d = ev_q & ~cfg_wdata[1:0];
    if (done_set) ev_d[0] = 1'b1;
    if (err_set)  ev_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      sd_q   <= 1'b0;
      tc_q   <= 1'b0;
      mask_q <= '0;
      ev_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      sd_q   <= sd_d;
      tc_q   <= tc_d;
      mask_q <= mask_d;
      ev_q   <= ev_d;
    end
  end

  assign start   = wr_idle && cfg_addr == REG_CTRL && cfg_wdata[0] && (cnt_q != '0);
  assign cnt_cfg = cnt_q;
  assign src_cfg = src_q;
  assign dst_cfg = dst_q;
  assign sd_mode = sd_q;
  assign tc_en   = tc_q;
  assign events  = ev_q;
  assign irq     = |(ev_q & mask_q);
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_cfg,
  input  logic [AW-1:0] src_cfg,
  input  logic [AW-1:0] dst_cfg,
  input  logic          sd_mode,
  input  logic          tc_en,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          pdack,
  output logic          tc_out,
  output logic          idle,
  output logic          dead,
  output logic          done_set,
  output logic          err_set
);
  import dmac_pkg::*;

  dmac_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    src_d    = src_q;
    dst_d    = dst_q;
    hold_d   = hold_q;
    hold_en  = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_READ;
        cnt_d   = cnt_cfg;
        src_d   = src_cfg;
        dst_d   = dst_cfg;
      end
      ST_READ: if (bus_err) begin
        state_d = ST_DEAD;
        hold_d  = '0;
        hold_en = 1'b1;
        err_set = 1'b1;
      end else if (bus_ack) begin
        state_d = ST_WRITE;
        hold_d  = bus_rdata;
        hold_en = 1'b1;
      end
      ST_WRITE: if (bus_err) begin
        state_d = ST_DEAD;
        hold_d  = '0;
        hold_en = 1'b1;
        err_set = 1'b1;
      end else if (bus_ack) begin
        cnt_d = cnt_q - 1'b1;
        src_d = src_q + 1'b1;
        dst_d = dst_q + 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d  = ST_IDLE;
          done_set = 1'b1;
        end else begin
          state_d = ST_READ;
        end
      end
      default: state_d = ST_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we    = (state_q == ST_WRITE);
  assign bus_addr  = bus_we ? dst_q : src_q;
  assign bus_wdata = hold_q;
  assign pdack     = !bus_err && (((state_q == ST_READ) && !sd_mode) ||
                                  ((state_q == ST_WRITE) && sd_mode));
  assign tc_out    = tc_en && bus_req;
  assign idle      = (state_q == ST_IDLE);
  assign dead      = (state_q == ST_DEAD);
endmodule

// File: rtl/dma_abort_ctrl.sv
module dma_abort_ctrl #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          pdack,
  output logic          tc_out,
  output logic          busy,
  output logic          dead,
  output logic          evt_done,
  output logic          evt_err,
  output logic          irq
);
  logic          rst_meta, rst_sync;
  logic          start, idle, done_set, err_set, sd_mode, tc_en;
  logic [CW-1:0] cnt_cfg;
  logic [AW-1:0] src_cfg, dst_cfg;
  logic [1:0]    events;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dmac_regs #(.DW(DW), .AW(AW), .CW(CW)) i_regs (
    .clk(clk), .rst_n(rst_sync), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .idle(idle), .done_set(done_set), .err_set(err_set),
    .start(start), .cnt_cfg(cnt_cfg), .src_cfg(src_cfg), .dst_cfg(dst_cfg),
    .sd_mode(sd_mode), .tc_en(tc_en), .events(events), .irq(irq)
  );

  dmac_seq #(.DW(DW), .AW(AW), .CW(CW)) i_seq (
    .clk(clk), .rst_n(rst_sync), .start(start), .cnt_cfg(cnt_cfg),
    .src_cfg(src_cfg), .dst_cfg(dst_cfg), .sd_mode(sd_mode), .tc_en(tc_en),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pdack(pdack), .tc_out(tc_out), .idle(idle),
    .dead(dead), .done_set(done_set), .err_set(err_set)
  );

  assign bus_oe   = bus_req;
  assign busy     = bus_req;
  assign evt_done = events[0];
  assign evt_err  = events[1];
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_oe,
  input logic          bus_ack,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          pdack,
  input logic          tc_out,
  input logic          busy,
  input logic          dead,
  input logic          evt_err
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!busy && !dead && !bus_oe && !pdack);
    end
  end

  a_r2_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_oe);

  a_r3_err_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (dead && evt_err && !bus_req));

  a_r5_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> (dead && !bus_req));

  a_r6_pdack_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !pdack);

  a_r8_tc_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> bus_req);

  a_r11_err_over_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err && bus_ack) |=> !busy);

  a_r12_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind dma_abort_ctrl dmac_chk #(.AW(AW), .DW(DW)) i_dmac_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_oe(bus_oe),
  .bus_ack(bus_ack), .bus_err(bus_err), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pdack(pdack), .tc_out(tc_out), .busy(busy),
  .dead(dead), .evt_err(evt_err)
);

// File: tb/test_dma_abort_ctrl.sv
`timescale 1ns/1ps
module test_dma_abort_ctrl;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ack = 1'b0;
  logic          bus_err = 1'b0;
  logic          bus_req, bus_we, bus_oe, pdack, tc_out;
  logic          busy, dead, evt_done, evt_err, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_abort_ctrl #(.DW(DW), .AW(AW), .CW(8)) i_dma_abort_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_oe(bus_oe),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .pdack(pdack), .tc_out(tc_out), .busy(busy), .dead(dead),
    .evt_done(evt_done), .evt_err(evt_err), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return DW'(a * 3 + 16'h0101);
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(!busy && !dead && !evt_done && !evt_err && !irq && !bus_oe, "R1 reset state",
        {busy, dead, evt_done, evt_err, irq, bus_oe}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // err_at < 0: no error; lat: wait cycles before each response
  task automatic run(input int cnt, input bit sd, input bit tc, input int err_at,
                     input int lat, input logic [1:0] mask);
    logic [AW-1:0] src, dst;
    int idx, waitc;
    bit phase_wr, err_now;
    src = AW'(16'h0100 + cnt * 16 + lat);
    dst = AW'(16'h2000 + cnt * 32);
    wr(3'd1, DW'(cnt));
    wr(3'd2, src);
    wr(3'd3, dst);
    wr(3'd4, {14'd0, mask});
    wr(3'd0, {13'd0, tc, sd, 1'b1});
    idx = 0;
    waitc = 0;
    while (busy) begin
      phase_wr = (idx % 2) == 1;
      chk(bus_oe && bus_we == phase_wr, "R2 oe/phase", {bus_oe, bus_we}, {1'b1, phase_wr});
      chk(tc_out == tc, "R8 tag", tc_out, tc);
      chk(bus_addr == (phase_wr ? dst : src) + AW'(idx / 2), "R9 address",
          bus_addr, (phase_wr ? dst : src) + AW'(idx / 2));
      err_now = 1'b0;
      if (waitc < lat) begin
        waitc++;
        #1;
        chk(pdack == (phase_wr == sd), "R7 pdack wait", pdack, phase_wr == sd);
        @(negedge clk);
        chk(busy && bus_we == phase_wr, "R12 wait holds", {busy, bus_we}, {1'b1, phase_wr});
        continue;
      end
      if (idx == err_at) begin
        err_now = 1'b1;
        bus_err = 1'b1;
        bus_ack = (lat > 0); // R11: error together with ack
      end else begin
        bus_ack = 1'b1;
        bus_rdata = mem_val(bus_addr);
      end
      #1;
      chk(pdack == (!err_now && (phase_wr == sd)), "R6/R7 pdack", pdack,
          !err_now && (phase_wr == sd));
      if (phase_wr && !err_now)
        chk(bus_wdata == mem_val(src + AW'(idx / 2)), "R9 write data",
            bus_wdata, mem_val(src + AW'(idx / 2)));
      @(negedge clk);
      bus_ack = 1'b0;
      bus_err = 1'b0;
      bus_rdata = '0;
      idx++;
      waitc = 0;
      if (err_now) break;
    end
    if (err_at >= 0) begin
      chk(dead && evt_err && !bus_req && !bus_oe && !pdack, "R3 error end",
          {dead, evt_err, bus_req, bus_oe, pdack}, 5'b11000);
      chk(bus_wdata == '0, "R5 hold discarded", bus_wdata, 0);
      chk(idx == err_at + 1, "R11 error wins", idx, err_at + 1);
      chk(irq == mask[1], "R4 error irq", irq, mask[1]);
      wr(3'd0, 16'h0001);
      repeat (2) @(negedge clk);
      chk(dead && !busy && !bus_req, "R5 start ignored when dead", {dead, busy}, 2'b10);
      do_reset();
    end else begin
      chk(idx == 2 * cnt && evt_done && !evt_err && !busy, "R9 done",
          {idx, evt_done, evt_err}, {2 * cnt, 2'b10});
      chk(irq == mask[0], "R4 done irq", irq, mask[0]);
      wr(3'd5, 16'h0002);
      chk(evt_done, "R10 zero bit keeps event", evt_done, 1);
      wr(3'd5, 16'h0001);
      chk(!evt_done && !irq, "R10 clear", {evt_done, irq}, 0);
    end
  endtask

  initial begin
    do_reset();
    for (int cnt = 1; cnt <= 3; cnt++)
      for (int sd = 0; sd < 2; sd++)
        for (int lat = 0; lat < 2; lat++)
          for (int e = -1; e < 2 * cnt; e++)
            run(cnt, sd[0], lat[0] ^ sd[0], e, lat,
                {e[0] ^ cnt[0], sd[0] ^ lat[0]});
    // R2: reset while a transaction waits for its acknowledge
    wr(3'd1, 16'd2);
    wr(3'd0, 16'h0005);
    repeat (2) @(negedge clk);
    chk(bus_req && bus_oe, "R2 open transaction", {bus_req, bus_oe}, 2'b11);
    rst_n = 1'b0;
    #1;
    chk(!bus_req && !bus_oe && !pdack && !tc_out && !busy, "R2 reset mid transaction",
        {bus_req, bus_oe, pdack, tc_out, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !dead, "R1 idle after reset", {busy, dead}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule